// File: doc/BRIEF.md
# Multi-Link Frame Sync and Power Control Shim

This block is the register-mapped control layer that sits beside a controller driving up to four serial audio links. It performs three jobs. It runs a power request and acknowledge handshake for each link. It generates a programmable frame-sync period and changes that period only on a software-requested sync event. It arms bank switches on several links and launches all of them in one cycle when software writes a single global trigger.

Software uses a 32-bit register port with two word addresses. Address 0 is the link control word. Bit n requests power for link n, and bit 8+n reports that link's active status. Address 1 is the sync word. Bits 14:0 hold the pending frame period. Bit 15 is the CPU sync request. Bits 19:16 are the per-link armed flags. Bit 24 is the global go trigger. Software polls bit 15 and bit 24 until they read 0, which tells it the hardware has acted. The power domain of each link reports ready on its own input. The block drives one frame-sync strobe and one bank-switch strobe per link.

Top module: `link_sync_shim`

## Requirements
- R1: A link's active status (control word bit 8+n) becomes 1 in the clock after its request bit n is 1 while its `pwr_ready` bit is 1. It never becomes 1 otherwise. `link_pwr_req` mirrors the request bits.
- R2: Active status returns to 0 only when the request bit is 0 and the domain reports not-ready. In every other combination the active status keeps its previous value.
- R3: `frame_sync` pulses for one cycle every P+1 cycles, where P is the period in use. After reset P is 0, so the pulse is present every cycle.
- R4: A period written to sync bits 14:0 becomes the period in use only at the frame-sync boundary that honours a pending CPU sync request. Writing the period alone does not change the pulse spacing.
- R5: Writing 1 to sync bit 15 sets the CPU sync request. The bit reads 1 until the boundary that applies the period, then reads 0. Writing 0 to it has no effect.
- R6: When go (bit 24) is set and some armed flag (bits 19:16) belongs to an active link, the next frame-sync boundary pulses `bank_switch` on exactly those armed, active links. The pulse lasts one cycle and coincides with `frame_sync`.
- R7: The cycle that issues a bank switch also clears all four armed flags, and the go bit then reads 0.
- R8: A go written while no armed flag belongs to an active link produces no bank-switch pulse. It reads 0 again from the next cycle on and leaves the armed flags as they were.
- R9: Undefined bits read 0 and ignore writes. Unmapped addresses read 0 and do not affect either register. Reset clears every field.
- R10: The period field supports the nominal value 0x176F, which gives a spacing of 6000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address (0 control, 1 sync) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwr_ready | input | 4 | Per-link power domain ready |
| link_pwr_req | output | 4 | Per-link power request to the domain |
| frame_sync | output | 1 | One-cycle frame boundary strobe |
| bank_switch | output | 4 | Per-link one-cycle bank switch strobe |

## Verification
The assertions take for granted that software never writes the sync word in the same cycle that a bank switch fires, because a write there would overwrite the hardware clearing of the armed flags. The go-clearing check also assumes that no new go write arrives in the cycle under test. The stimulus respects both conditions. Each write is followed by observation-only cycles, and a new sync write is issued only after any pending switch has completed or been dropped. Power-ready inputs change only between writes, away from the clock edge.

// File: rtl/shim_pkg.sv
package shim_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int MAX_LINKS  = 4;
    localparam int ACT_LSB    = 8;
    localparam int ARM_LSB    = 16;
    localparam int GO_BIT     = 24;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SYNC = 2'd1;
endpackage

// File: rtl/shim_power_lane.sv
module shim_power_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_req,
    input  logic ready,
    output logic req,
    output logic active
);
    typedef struct packed {
        logic req;
        logic act;
    } lane_t;

    lane_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.req && ready)
            s_d.act = 1'b1;
        else if (!s_q.req && !ready)
            s_d.act = 1'b0;
        if (wr_en)
            s_d.req = wr_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req    = s_q.req;
    assign active = s_q.act;
endmodule

// File: rtl/shim_frame_timer.sv
module shim_frame_timer #(
    parameter int PERIOD_W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PERIOD_W-1:0] wr_period,
    input  logic                wr_cpu,
    output logic                wrap,
    output logic                pulse,
    output logic [PERIOD_W-1:0] period_sw,
    output logic [PERIOD_W-1:0] period_act,
    output logic                cpu_req
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic [PERIOD_W-1:0] per_act;
        logic [PERIOD_W-1:0] per_sw;
        logic                cpu;
        logic                pulse;
    } tmr_t;

    tmr_t s_d, s_q;
    logic at_end;

    always_comb begin
        at_end  = (s_q.cnt == s_q.per_act);
        s_d     = s_q;
        s_d.pulse = at_end;
        s_d.cnt   = at_end ? '0 : s_q.cnt + 1'b1;
        if (at_end && s_q.cpu) begin
            s_d.per_act = s_q.per_sw;
            s_d.cpu     = 1'b0;
        end
        if (wr_en) begin
            s_d.per_sw = wr_period;
            if (wr_cpu)
                s_d.cpu = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wrap       = at_end;
    assign pulse      = s_q.pulse;
    assign period_sw  = s_q.per_sw;
    assign period_act = s_q.per_act;
    assign cpu_req    = s_q.cpu;
endmodule

// File: rtl/shim_bank_sync.sv
module shim_bank_sync #(
    parameter int NUM_LINKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINKS-1:0] wr_arm,
    input  logic                 wr_go,
    input  logic [NUM_LINKS-1:0] link_act,
    input  logic                 wrap,
    output logic [NUM_LINKS-1:0] arm,
    output logic                 go,
    output logic [NUM_LINKS-1:0] strobe
);
    typedef struct packed {
        logic [NUM_LINKS-1:0] arm;
        logic                 go;
        logic [NUM_LINKS-1:0] strobe;
    } bank_t;

    bank_t s_d, s_q;
    logic [NUM_LINKS-1:0] eligible;

    always_comb begin
        eligible   = s_q.arm & link_act;
        s_d        = s_q;
        s_d.strobe = '0;
        if (s_q.go) begin
            if (eligible == '0) begin
                s_d.go = 1'b0;
            end else if (wrap) begin
                s_d.strobe = eligible;
                s_d.arm    = '0;
                s_d.go     = 1'b0;
            end
        end
        if (wr_en) begin
            s_d.arm = wr_arm;
            if (wr_go)
                s_d.go = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign arm    = s_q.arm;
    assign go     = s_q.go;
    assign strobe = s_q.strobe;
endmodule

// File: rtl/link_sync_shim.sv
module link_sync_shim
    import shim_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int PERIOD_W  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_LINKS-1:0] pwr_ready,
    output logic [NUM_LINKS-1:0] link_pwr_req,
    output logic                 frame_sync,
    output logic [NUM_LINKS-1:0] bank_switch
);
    localparam int CPU_BIT = PERIOD_W;

    logic                 wr_ctrl, wr_sync;
    logic [NUM_LINKS-1:0] link_act;
    logic                 wrap;
    logic [PERIOD_W-1:0]  period_sw, period_act;
    logic                 cpu_req;
    logic [NUM_LINKS-1:0] arm_flags;
    logic                 go_flag;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_sync = reg_wr && (reg_addr == ADDR_SYNC);

    for (genvar n = 0; n < NUM_LINKS; n++) begin : g_lane
        shim_power_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_ctrl),
            .wr_req (reg_wdata[n]),
            .ready  (pwr_ready[n]),
            .req    (link_pwr_req[n]),
            .active (link_act[n])
        );
    end

    shim_frame_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_sync),
        .wr_period  (reg_wdata[PERIOD_W-1:0]),
        .wr_cpu     (reg_wdata[CPU_BIT]),
        .wrap       (wrap),
        .pulse      (frame_sync),
        .period_sw  (period_sw),
        .period_act (period_act),
        .cpu_req    (cpu_req)
    );

    shim_bank_sync #(.NUM_LINKS(NUM_LINKS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_sync),
        .wr_arm   (reg_wdata[ARM_LSB +: NUM_LINKS]),
        .wr_go    (reg_wdata[GO_BIT]),
        .link_act (link_act),
        .wrap     (wrap),
        .arm      (arm_flags),
        .go       (go_flag),
        .strobe   (bank_switch)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[NUM_LINKS-1:0]          = link_pwr_req;
                reg_rdata[ACT_LSB +: NUM_LINKS]   = link_act;
            end
            ADDR_SYNC: begin
                reg_rdata[PERIOD_W-1:0]           = period_sw;
                reg_rdata[CPU_BIT]                = cpu_req;
                reg_rdata[ARM_LSB +: NUM_LINKS]   = arm_flags;
                reg_rdata[GO_BIT]                 = go_flag;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/shim_checker.sv
module shim_checker
    import shim_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int PERIOD_W  = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [NUM_LINKS-1:0] pwr_ready,
    input logic [NUM_LINKS-1:0] link_pwr_req,
    input logic                 frame_sync,
    input logic [NUM_LINKS-1:0] bank_switch,
    input logic [NUM_LINKS-1:0] link_act,
    input logic [NUM_LINKS-1:0] arm_flags,
    input logic                 go_flag,
    input logic                 cpu_req,
    input logic [PERIOD_W-1:0]  period_act
);
    logic sync_go_wr;
    assign sync_go_wr = reg_wr && (reg_addr == ADDR_SYNC) && reg_wdata[GO_BIT];

    // R1: active rises only after request and ready were both present
    a_r1_act_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_act & ~$past(link_act)) & ~$past(link_pwr_req & pwr_ready)) == '0);

    // R2: active falls only after request and ready were both absent
    a_r2_act_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((~link_act & $past(link_act)) & $past(link_pwr_req | pwr_ready)) == '0);

    // R3: strobe is a single cycle when the period is non-zero
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && period_act != '0) |=> !frame_sync);

    // R5: CPU request clears only on a frame boundary
    a_r5_cpu_clear_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_req) |-> frame_sync);

    // R6: bank switch coincides with frame sync
    a_r6_bank_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_switch != '0) |-> frame_sync);

    // R6: bank switch only on links that were active
    a_r6_bank_active_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_switch & ~$past(link_act)) == '0);

    // R7: firing leaves go and every armed flag cleared
    a_r7_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_switch != '0 && !$past(reg_wr)) |-> (!go_flag && arm_flags == '0));

    // R8: go with nothing eligible drops on the next cycle
    a_r8_go_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (go_flag && (arm_flags & link_act) == '0 && !sync_go_wr) |=> !go_flag);
endmodule

bind link_sync_shim shim_checker #(.NUM_LINKS(NUM_LINKS), .PERIOD_W(PERIOD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .pwr_ready    (pwr_ready),
    .link_pwr_req (link_pwr_req),
    .frame_sync   (frame_sync),
    .bank_switch  (bank_switch),
    .link_act     (link_act),
    .arm_flags    (arm_flags),
    .go_flag      (go_flag),
    .cpu_req      (cpu_req),
    .period_act   (period_act)
);

// File: tb/test_link_sync_shim.sv
`timescale 1ns/1ps
module test_link_sync_shim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwr_ready = 4'd0;
    logic [3:0]  link_pwr_req;
    logic        frame_sync;
    logic [3:0]  bank_switch;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    link_sync_shim i_link_sync_shim (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_ready(pwr_ready),
        .link_pwr_req(link_pwr_req), .frame_sync(frame_sync), .bank_switch(bank_switch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // measure spacing between two frame_sync pulses
    task automatic gap(output int g);
        int k;
        k = 0;
        while (frame_sync !== 1'b1 && k < 20000) begin @(negedge clk); k++; end
        g = 0;
        do begin @(negedge clk); g++; end while (frame_sync !== 1'b1 && g < 20000);
    endtask

    task automatic cpu_wait();
        logic [31:0] d;
        int k;
        k = 0;
        rd(2'd1, d);
        while (d[15] && k < 20000) begin @(negedge clk); rd(2'd1, d); k++; end
        check("R5 cpu request self-clears", {31'd0, d[15]}, 32'd0);
    endtask

    task automatic set_active(input logic [3:0] m);
        pwr_ready = m;
        wr(2'd0, {28'd0, m});
        idle(1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [3:0]  m_act;
        int g;
        repeat (3) @(negedge clk);
        // R9 reset state
        rd(2'd0, d); check("R9 reset ctrl", d, 32'd0);
        rd(2'd1, d); check("R9 reset sync", d, 32'd0);
        check("R9 reset outputs", {27'd0, link_pwr_req, bank_switch[0]}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        // R3 period 0 after reset: pulse every cycle
        gap(g); check("R3 reset spacing", g, 1);

        // R1 R2 power handshake sweep over request x ready
        m_act = 4'd0;
        for (int r = 0; r < 16; r++) begin
            for (int y = 0; y < 16; y++) begin
                pwr_ready = y[3:0];
                wr(2'd0, {28'd0, r[3:0]});
                idle(1);
                m_act = (r[3:0] & y[3:0]) | (m_act & (r[3:0] | y[3:0]));
                rd(2'd0, d);
                check("R1 R2 ctrl readback", d, {20'd0, m_act, 4'd0, r[3:0]});
                check("R1 request pins", {28'd0, link_pwr_req}, {28'd0, r[3:0]});
            end
        end

        // R9 undefined bits and unmapped addresses
        set_active(4'd0);
        pwr_ready = 4'hF;
        wr(2'd0, 32'hFFFF_FFFF);
        idle(1);
        rd(2'd0, d); check("R9 ctrl undefined bits", d, 32'h0000_0F0F);
        wr(2'd1, 32'hFEF0_0000);
        rd(2'd1, d); check("R9 sync undefined bits", d, 32'd0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R9 unmapped read 2", d, 32'd0);
        rd(2'd3, d); check("R9 unmapped read 3", d, 32'd0);
        rd(2'd0, d); check("R9 ctrl untouched", d, 32'h0000_0F0F);
        rd(2'd1, d); check("R9 sync untouched", d, 32'd0);

        // R3 R4 R5 period sweep
        for (int p = 0; p < 8; p++) begin
            wr(2'd1, 32'h0000_8000 | p);
            rd(2'd1, d);
            check("R5 cpu bit set after write", {31'd0, d[15]}, 32'd1);
            cpu_wait();
            rd(2'd1, d); check("R4 period readback", d, p);
            gap(g); check("R3 spacing", g, p + 1);
            wr(2'd1, (p + 5) % 8);
            idle(2);
            gap(g); check("R4 period without cpu keeps spacing", g, p + 1);
            rd(2'd1, d); check("R5 write of 0 leaves cpu clear", {31'd0, d[15]}, 32'd0);
        end

        // R10 nominal period
        wr(2'd1, 32'h0000_8000 | 32'h176F);
        cpu_wait();
        gap(g); check("R10 nominal spacing", g, 6000);
        rd(2'd1, d); check("R10 readback", d, 32'h176F);

        // back to a short period for bank tests
        wr(2'd1, 32'h0000_8003);
        cpu_wait();

        // R6 R7 R8 bank switch sweep over active x armed
        for (int m = 0; m < 16; m++) begin
            set_active(m[3:0]);
            for (int a = 0; a < 16; a++) begin
                logic [3:0] seen;
                int hits;
                bit on_frame;
                logic [3:0] eff;
                eff = a[3:0] & m[3:0];
                seen = 4'd0; hits = 0; on_frame = 1'b1;
                wr(2'd1, 32'h0100_0003 | (a << 16));
                for (int i = 0; i < 12; i++) begin
                    if (bank_switch != 4'd0) begin
                        hits++; seen = bank_switch;
                        if (frame_sync !== 1'b1) on_frame = 1'b0;
                    end
                    @(negedge clk);
                end
                rd(2'd1, d);
                if (eff != 4'd0) begin
                    check("R6 strobe links", {28'd0, seen}, {28'd0, eff});
                    check("R6 one strobe on frame", {30'd0, on_frame, hits == 1}, 32'd3);
                    check("R7 cleared after fire", d, 32'd3);
                end else begin
                    check("R8 no strobe", hits, 0);
                    check("R8 go drops, arm kept", d, 32'd3 | (a << 16));
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule